// File: doc/BRIEF.md
# External Interrupt Controller

This block collects level-sensitive interrupt lines from on-chip devices and forwards the most urgent one to a single processor context. Each source has a latched pending flag, a software-set urgency level and a mask bit. A global threshold lets software raise the bar below which requests are held back. When a request clears the bar, a single request line to the processor goes high.

The processor services interrupts through one shared claim/complete word. Reading that word returns the identifier of the most urgent eligible source and, in the same bus operation, takes that source out of the pending set. Writing the identifier back marks service as finished, and the source may then request again. All configuration and status sit behind a simple 32-bit register bus. The bus accepts one access per cycle and returns read data one cycle later.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every urgency level, mask bit, pending flag and the threshold read back zero. `irq_req` is low and a claim read returns 0.
- R2: A source whose line is high while it is not in service sets its pending flag on the next clock edge. The flag stays set after the line drops, until the source is claimed. Pending flags read at 0x100 (bit n = source n, bit 0 reads 0) and 0x104 (bit n = source n+32).
- R3: The urgency of source n (1..51) sits at byte address 4·n, bits [2:0]. Bits above read as 0. Address 0 reads 0 and ignores writes. Level 0 is never selected.
- R4: The threshold sits at 0x300, bits [2:0]. A source is eligible only when its level is strictly greater than the threshold, so 7 blocks every source.
- R5: `irq_req` is high exactly when at least one source is pending, unmasked and eligible under R4.
- R6: A read of 0x304 returns the identifier of the eligible, pending, unmasked source with the highest level. Among equal levels the lowest identifier wins. The read returns 0 when no source qualifies, and it is legal while `irq_req` is low.
- R7: A claim clears the returned source's pending flag in the same operation. That source cannot become pending again while it is in service, even with its line high.
- R8: Writing an in-service identifier to 0x304 ends its service, and a line still high re-pends it one cycle later. Writing any identifier that is not in service has no effect.
- R9: Mask bits sit at 0x200 and 0x204, with the same bit layout as R2 (1 = enabled). A masked source still latches pending but is never selected and does not raise `irq_req`.
- R10: An access with a nonzero `bus_addr[1:0]` is ignored. A write changes nothing. A read returns 0 and claims nothing.
- R11: Read data is presented on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NSRC (51), indexed [NSRC:1] | Level-sensitive source lines; bit n is source n |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (10) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| irq_req | output | 1 | Request line to the processor |

## Verification
A claim can coincide with a source line rising. It can also coincide with a completion while the line stays high. In each case the clearing of the pending flag and the line's attempt to set it meet in the same edge. The bench holds a line high across a claim and checks that the pending word stays zero through service. It then checks that a stray completion keeps it zero, and that only the correct completion re-pends the source exactly one cycle later. Tie-breaking and threshold boundaries come from a table of paired sources whose levels are equal, straddle the threshold or sit exactly on it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // register word indices (byte address / 4)
  localparam int PRIO_WBASE = 0;
  localparam int PEND_WBASE = 64;
  localparam int EN_WBASE   = 128;
  localparam int THR_WORD   = 192;
  localparam int CLAIM_WORD = 193;

  typedef enum logic [2:0] {
    RGN_PRIO,
    RGN_PEND,
    RGN_EN,
    RGN_THR,
    RGN_CLAIM,
    RGN_NONE
  } region_e;

  function automatic region_e decode_word(input int widx);
    if (widx < PEND_WBASE)       return RGN_PRIO;
    else if (widx < EN_WBASE)    return RGN_PEND;
    else if (widx < THR_WORD)    return RGN_EN;
    else if (widx == THR_WORD)   return RGN_THR;
    else if (widx == CLAIM_WORD) return RGN_CLAIM;
    else                         return RGN_NONE;
  endfunction

  // bitmap placement of a source identifier
  function automatic int map_word(input int id);
    return id / 32;
  endfunction

  function automatic int map_bit(input int id);
    return id % 32;
  endfunction

  // strict comparison: equal levels never displace an earlier (lower) id
  function automatic logic outranks(input int cand, input int cur);
    return cand > cur;
  endfunction

endpackage

// File: rtl/irqc_gate.sv
module irqc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic take,
  input  logic retire,
  output logic pend,
  output logic busy
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      busy <= 1'b0;
    end else if (take) begin
      pend <= 1'b0;
      busy <= 1'b1;
    end else if (retire && busy) begin
      busy <= 1'b0;
    end else if (level && !busy) begin
      pend <= 1'b1;
    end
  end

  assert_claim_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!pend && busy));

  assert_no_pend_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && busy));

  assert_stray_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !busy && !take) |=> !busy);

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int NSRC = 51,
  parameter int PW   = 3,
  parameter int IDW  = 6
) (
  input  logic [NSRC:1]         pend,
  input  logic [NSRC:1]         en,
  input  logic [NSRC:1][PW-1:0] prio,
  input  logic [PW-1:0]         thr,
  output logic [IDW-1:0]        best_id,
  output logic [PW-1:0]         best_prio
);

  // linear scan, starting the bar at the threshold
  always_comb begin
    best_id   = '0;
    best_prio = thr;
    for (int i = 1; i <= NSRC; i++) begin
      if (pend[i] && en[i] && outranks(int'(prio[i]), int'(best_prio))) begin
        best_id   = IDW'(i);
        best_prio = prio[i];
      end
    end
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC = 51,
  parameter int PW   = 3,
  parameter int AW   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC:1]   irq_lines,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            bus_rvalid,
  output logic            irq_req
);

  localparam int IDW   = $clog2(NSRC + 1);
  localparam int NMAPW = (NSRC + 32) / 32;

  logic [NSRC:1][PW-1:0] prio_q;
  logic [NSRC:1]         en_q;
  logic [PW-1:0]         thr_q;
  logic [NSRC:1]         pend_w;
  logic [NSRC:1]         busy_w;
  logic [IDW-1:0]        best_id;
  logic [PW-1:0]         best_prio;

  // bus decode
  logic          acc_ok;
  logic [AW-3:0] widx;
  region_e       rgn;
  logic          wr_ok, rd_ok, claim_rd, retire_wr;

  assign acc_ok    = bus_valid && (bus_addr[1:0] == 2'b00);
  assign widx      = bus_addr[AW-1:2];
  assign rgn       = decode_word(int'(widx));
  assign wr_ok     = acc_ok && bus_write;
  assign rd_ok     = acc_ok && !bus_write;
  assign claim_rd  = rd_ok && (rgn == RGN_CLAIM);
  assign retire_wr = wr_ok && (rgn == RGN_CLAIM);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else begin
      if (wr_ok && rgn == RGN_THR) thr_q <= bus_wdata[PW-1:0];
      for (int i = 1; i <= NSRC; i++) begin
        if (wr_ok && rgn == RGN_PRIO && int'(widx) == PRIO_WBASE + i)
          prio_q[i] <= bus_wdata[PW-1:0];
        if (wr_ok && rgn == RGN_EN && int'(widx) == EN_WBASE + map_word(i))
          en_q[i] <= bus_wdata[map_bit(i)];
      end
    end
  end

  // per-source gateways
  for (genvar g = 1; g <= NSRC; g++) begin : g_gate
    irqc_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .level  (irq_lines[g]),
      .take   (claim_rd && (best_id == IDW'(g))),
      .retire (retire_wr && (bus_wdata == 32'(g))),
      .pend   (pend_w[g]),
      .busy   (busy_w[g])
    );
  end

  irqc_arb #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_arb (
    .pend      (pend_w),
    .en        (en_q),
    .prio      (prio_q),
    .thr       (thr_q),
    .best_id   (best_id),
    .best_prio (best_prio)
  );

  assign irq_req = (best_id != '0);

  // read path
  logic [NMAPW*32-1:0] pend_map, en_map;
  logic [31:0]         rd_val;

  always_comb begin
    pend_map = '0;
    en_map   = '0;
    for (int i = 1; i <= NSRC; i++) begin
      pend_map[i] = pend_w[i];
      en_map[i]   = en_q[i];
    end
    rd_val = '0;
    case (rgn)
      RGN_PRIO: begin
        for (int i = 1; i <= NSRC; i++)
          if (int'(widx) == PRIO_WBASE + i) rd_val = {{(32-PW){1'b0}}, prio_q[i]};
      end
      RGN_PEND: begin
        for (int w = 0; w < NMAPW; w++)
          if (int'(widx) == PEND_WBASE + w) rd_val = pend_map[w*32 +: 32];
      end
      RGN_EN: begin
        for (int w = 0; w < NMAPW; w++)
          if (int'(widx) == EN_WBASE + w) rd_val = en_map[w*32 +: 32];
      end
      RGN_THR:   rd_val = {{(32-PW){1'b0}}, thr_q};
      RGN_CLAIM: rd_val = {{(32-IDW){1'b0}}, best_id};
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_ok ? rd_val : 32'd0;
    end
  end

  assert_winner_above_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (best_id != '0) |-> (best_prio > thr_q));

  assert_empty_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && !irq_req) |=> (bus_rdata == 32'd0));

  assert_misaligned_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[1:0] != 2'b00) |=> ($stable(thr_q) && $stable(en_q) && $stable(prio_q)));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

endmodule

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:1] src = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic last_rv;

  always #2.5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(src),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_req(irq_req)
  );

  // {srcA[6], lvlA[3], srcB[6], lvlB[3], thr[3], expected id[6]}
  localparam logic [26:0] VEC [8] = '{
    {6'd5,  3'd3, 6'd9,  3'd6, 3'd0, 6'd9},   // higher level wins
    {6'd5,  3'd6, 6'd9,  3'd6, 3'd0, 6'd5},   // tie -> lower id
    {6'd40, 3'd2, 6'd3,  3'd1, 3'd1, 6'd40},  // level equal to thr masked
    {6'd12, 3'd4, 6'd33, 3'd4, 3'd4, 6'd0},   // both on thr
    {6'd51, 3'd7, 6'd1,  3'd0, 3'd0, 6'd51},  // level 0 never
    {6'd20, 3'd5, 6'd31, 3'd5, 3'd2, 6'd20},
    {6'd32, 3'd1, 6'd50, 3'd2, 3'd0, 6'd50},
    {6'd7,  3'd7, 6'd8,  3'd7, 3'd7, 6'd0}    // thr 7 blocks all
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; last_rv = bus_rvalid;
    bus_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] m;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk({31'd0, irq_req}, 32'd0, "R1 irq_req");
    rd(10'h300, d); chk(d, 32'd0, "R1 threshold");
    rd(10'h100, d); chk(d, 32'd0, "R1 pending lo");
    rd(10'h104, d); chk(d, 32'd0, "R1 pending hi");
    rd(10'h200, d); chk(d, 32'd0, "R1 enable lo");
    rd(10'h028, d); chk(d, 32'd0, "R1 level src10");
    rd(10'h304, d); chk(d, 32'd0, "R1 claim");

    // table of paired-source scenarios (R4 R5 R6)
    for (int v = 0; v < 8; v++) begin
      int a, b, pa, pb, th, ex;
      a  = int'(VEC[v][26:21]); pa = int'(VEC[v][20:18]);
      b  = int'(VEC[v][17:12]); pb = int'(VEC[v][11:9]);
      th = int'(VEC[v][8:6]);   ex = int'(VEC[v][5:0]);
      wr(10'(a*4), 32'(pa));
      wr(10'(b*4), 32'(pb));
      wr(10'h300, 32'(th));
      m = (64'd1 << a) | (64'd1 << b);
      wr(10'h200, m[31:0]);
      wr(10'h204, m[63:32]);
      src[a] = 1'b1; src[b] = 1'b1;
      idle(2);
      chk({31'd0, irq_req}, {31'd0, ex != 0}, "R5 request line");
      rd(10'h304, d);
      chk(d, 32'(ex), "R6 R4 claim winner");
      // cleanup: make both claimable, drain, retire, clear
      src = '0;
      wr(10'h300, 32'd0);
      wr(10'(a*4), 32'd7);
      wr(10'(b*4), 32'd7);
      rd(10'h304, d);
      rd(10'h304, d);
      wr(10'h304, 32'(a));
      wr(10'h304, 32'(b));
      wr(10'(a*4), 32'd0);
      wr(10'(b*4), 32'd0);
      wr(10'h200, 32'd0);
      wr(10'h204, 32'd0);
    end

    // R3 level register width and id 0
    wr(10'h028, 32'hFFFF_FFFF);
    rd(10'h028, d); chk(d, 32'd7, "R3 level bits");
    wr(10'h000, 32'd5);
    rd(10'h000, d); chk(d, 32'd0, "R3 id0 reads 0");

    // R2 latch, R9 masked source
    src[10] = 1'b1;
    idle(2);
    rd(10'h100, d); chk(d, 32'd1 << 10, "R2 pending set");
    chk({31'd0, irq_req}, 32'd0, "R9 masked no request");
    src[10] = 1'b0;
    idle(2);
    rd(10'h100, d); chk(d, 32'd1 << 10, "R2 pending held");
    wr(10'h200, 32'd1 << 10);
    idle(1);
    chk({31'd0, irq_req}, 32'd1, "R5 request after enable");

    // R10 misaligned accesses
    wr(10'h301, 32'd7);
    rd(10'h300, d); chk(d, 32'd0, "R10 misaligned write");
    rd(10'h306, d); chk(d, 32'd0, "R10 misaligned read");
    rd(10'h100, d); chk(d, 32'd1 << 10, "R10 no claim effect");

    // R6 R7 claim, R11 latency
    rd(10'h304, d); chk(d, 32'd10, "R6 claim id");
    chk({31'd0, last_rv}, 32'd1, "R11 rvalid");
    rd(10'h100, d); chk(d, 32'd0, "R7 pending cleared");
    src[10] = 1'b1;
    idle(3);
    rd(10'h100, d); chk(d, 32'd0, "R7 blocked in service");
    chk({31'd0, irq_req}, 32'd0, "R7 no request in service");

    // R8 completion
    wr(10'h304, 32'd11);
    idle(2);
    rd(10'h100, d); chk(d, 32'd0, "R8 stray completion ignored");
    wr(10'h304, 32'd10);
    idle(1);
    rd(10'h100, d); chk(d, 32'd1 << 10, "R8 re-pend after completion");

    // R9 upper mask word layout
    wr(10'h204, 32'd2);
    rd(10'h204, d); chk(d, 32'd2, "R9 mask word hi");

    // R6 empty claim while request low
    rd(10'h304, d); chk(d, 32'd10, "R6 claim again");
    src[10] = 1'b0;
    wr(10'h304, 32'd10);
    idle(2);
    rd(10'h304, d); chk(d, 32'd0, "R6 empty claim");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule